// File: doc/BRIEF.md
# Printer Port Register Interface

This block sits on a small register bus and presents a classic parallel printer port to the host as three byte-wide registers: a data register, a status register and a control register. The host moves a byte to the peripheral by loading the data register and then driving the strobe bit of the control register from 0 to 1 while the select and initialize conditions hold. That control write itself performs the transfer: the output latch is presented on `pdata_o` and `byte_sent_o` pulses for one clock.

The peripheral status lines (busy, acknowledge, online, error, paper-out, timeout) are modelled inside the block. After a byte goes out, busy drops. Later status reads then run a short handshake: the first read with busy low and strobe low clears acknowledge, and the next one sets acknowledge and busy again. A control write with strobe low, select and init high raises a level interrupt if the stored control value already had interrupt enable set. Any status read clears that interrupt.

The data register reads back either the output latch or an input latch, depending on the direction bit. The input latch follows `pdata_i` while the port is set for input.

Top module: `lpt_regif`

## Requirements
- R1: After reset both data latches hold 0xFF, status reads 0xF9, control reads 0xCC, and `irq_o` and `byte_sent_o` are 0.
- R2: Bus offset 0 selects data, 1 selects status and 2 selects control; a read of offsets 3 to 7 returns 0xFF. Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.
- R3: Control bits 7 and 6 always read as 1, whatever was written to them.
- R4: A control write with bit 2 (initialize) at 0 sets status to 0xD8 (bit 7 busy-complement, bit 6 acknowledge, bit 4 online, bit 3 error-complement).
- R5: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7. If the stored control value had bit 0 at 0, `byte_sent_o` is high for exactly one clock, in the cycle after the write, and `pdata_o` carries the output latch.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt pending flag when the stored control value (before this write) has bit 4 (interrupt enable) at 1. `irq_o` is the level of that flag.
- R7: A status read clears the interrupt pending flag.
- R8: A status read taken while status bit 7 is 0 and control bit 0 is 0 returns the old status, then updates it: if bit 6 was 1 it is cleared; if bit 6 was 0, bits 6 and 7 are both set. With status bit 7 at 1 or control bit 0 at 1, a status read leaves status unchanged.
- R9: A data read returns the input latch when control bit 5 (direction) is 1, and the output latch when it is 0. The input latch samples `pdata_i` every clock while bit 5 is 1.
- R10: A data write updates the output latch and `pdata_o` without producing a `byte_sent_o` pulse or touching status or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt level |
| pdata_o | output | 8 | Output data latch toward the printer |
| byte_sent_o | output | 1 | One-clock pulse when a byte is sent |
| pdata_i | input | 8 | Data lines from the printer for input direction |

## Verification
The assertions assume that the host never raises the read and write strobes in the same clock. Read side effects (the interrupt clear and the acknowledge handshake) and write side effects are therefore never merged into one cycle. The bench drives every access as a single-clock strobe from a task that raises exactly one of them. It always leaves at least one idle clock between accesses, so every property sees clean, separate bus cycles.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int BYTE_W = 8;

  // register offsets
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_BUSY_N = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_ERR_N  = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR   = 5;
  localparam int CT_IRQEN = 4;
  localparam int CT_SEL   = 3;
  localparam int CT_INIT  = 2;
  localparam int CT_ALF   = 1;
  localparam int CT_STB   = 0;

  localparam logic [BYTE_W-1:0] CTRL_FORCED = 8'hC0;
  localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;
  localparam logic [BYTE_W-1:0] DATA_RST    = 8'hFF;
  localparam logic [BYTE_W-1:0] STAT_RST    = 8'hF9;
  localparam logic [BYTE_W-1:0] CTRL_RST    = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_INIT   = 8'hD8;

  typedef struct packed {
    logic do_init;
    logic do_busy_clr;
    logic do_send;
    logic do_irq;
  } ctrl_evt_t;

endpackage

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output ctrl_evt_t         evt
);

  logic [BYTE_W-1:0] ctrl_new;
  logic              armed;

  assign ctrl_new = wdata | CTRL_FORCED;
  assign armed    = ctrl_new[CT_INIT] && ctrl_new[CT_SEL];

  always_comb begin
    evt = '0;
    if (wr_en) begin
      evt.do_init     = !ctrl_new[CT_INIT];
      evt.do_busy_clr = armed && ctrl_new[CT_STB];
      evt.do_send     = armed && ctrl_new[CT_STB] && !ctrl_q[CT_STB];
      evt.do_irq      = armed && !ctrl_new[CT_STB] && ctrl_q[CT_IRQEN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_en) begin
      ctrl_q <= ctrl_new;
    end
  end

  AST_SEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    evt.do_send |-> (ctrl_q[CT_STB] == 1'b0)); // R5

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(evt.do_irq && evt.do_busy_clr)); // R6

endmodule

// File: rtl/lpt_status_reg.sv
module lpt_status_reg
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_evt_t         evt,
  input  logic              rd_stat,
  input  logic              ctrl_stb,
  output logic [BYTE_W-1:0] sts_q,
  output logic              irq_q
);

  logic [BYTE_W-1:0] sts_nxt;
  logic              hs_active;

  assign hs_active = !sts_q[ST_BUSY_N] && !ctrl_stb;

  always_comb begin
    sts_nxt = sts_q;
    if (evt.do_init) begin
      sts_nxt = STAT_INIT;
    end else if (evt.do_busy_clr) begin
      sts_nxt[ST_BUSY_N] = 1'b0;
    end else if (rd_stat && hs_active) begin
      if (sts_q[ST_ACK]) begin
        sts_nxt[ST_ACK] = 1'b0;
      end else begin
        sts_nxt[ST_ACK]    = 1'b1;
        sts_nxt[ST_BUSY_N] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= STAT_RST;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_nxt;
      if (evt.do_irq) begin
        irq_q <= 1'b1;
      end else if (rd_stat) begin
        irq_q <= 1'b0;
      end
    end
  end

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && hs_active && sts_q[ST_ACK] && !evt.do_init && !evt.do_busy_clr)
      |=> !sts_q[ST_ACK]); // R8

  AST_ACK_RISES: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && hs_active && !sts_q[ST_ACK] && !evt.do_init && !evt.do_busy_clr)
      |=> (sts_q[ST_ACK] && sts_q[ST_BUSY_N])); // R8

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(evt.do_irq)); // R6

endmodule

// File: rtl/lpt_data_path.sv
module lpt_data_path
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              send,
  input  logic              dir_in,
  input  logic [BYTE_W-1:0] pdata_i,
  output logic [BYTE_W-1:0] dout_q,
  output logic [BYTE_W-1:0] din_q,
  output logic              sent_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= DATA_RST;
      din_q  <= DATA_RST;
      sent_q <= 1'b0;
    end else begin
      sent_q <= send;
      if (data_wr) begin
        dout_q <= wdata;
      end
      if (dir_in) begin
        din_q <= pdata_i;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sent_q |=> !sent_q); // R5

  AST_DOUT_STEADY_ON_SEND: assert property (@(posedge clk) disable iff (rst)
    sent_q |-> $stable(dout_q)); // R5

endmodule

// File: rtl/lpt_regif.sv
module lpt_regif
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o,
  output logic [7:0]        pdata_o,
  output logic              byte_sent_o,
  input  logic [7:0]        pdata_i
);

  localparam int OFS_W = 3;

  logic [OFS_W-1:0]  ofs;
  logic              sel_data, sel_stat, sel_ctrl;
  logic [BYTE_W-1:0] ctrl_q, sts_q, dout_q, din_q;
  logic              irq_q, sent_q;
  ctrl_evt_t         evt;
  logic [BYTE_W-1:0] rd_mux;

  generate
    if (ADDR_W >= OFS_W) begin : g_mask
      assign ofs = bus_addr[OFS_W-1:0];
    end else begin : g_pad
      assign ofs = {{(OFS_W-ADDR_W){1'b0}}, bus_addr};
    end
  endgenerate

  assign sel_data = (ofs == OFS_DATA);
  assign sel_stat = (ofs == OFS_STAT);
  assign sel_ctrl = (ofs == OFS_CTRL);

  lpt_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr && sel_ctrl),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q),
    .evt    (evt)
  );

  lpt_status_reg u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .rd_stat  (bus_rd && sel_stat),
    .ctrl_stb (ctrl_q[CT_STB]),
    .sts_q    (sts_q),
    .irq_q    (irq_q)
  );

  lpt_data_path u_data (
    .clk     (clk),
    .rst     (rst),
    .data_wr (bus_wr && sel_data),
    .wdata   (bus_wdata),
    .send    (evt.do_send),
    .dir_in  (ctrl_q[CT_DIR]),
    .pdata_i (pdata_i),
    .dout_q  (dout_q),
    .din_q   (din_q),
    .sent_q  (sent_q)
  );

  always_comb begin
    rd_mux = UNMAPPED_RD;
    if (sel_data) begin
      rd_mux = ctrl_q[CT_DIR] ? din_q : dout_q;
    end else if (sel_stat) begin
      rd_mux = sts_q;
    end else if (sel_ctrl) begin
      rd_mux = ctrl_q | CTRL_FORCED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= UNMAPPED_RD;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  assign irq_o       = irq_q;
  assign pdata_o     = dout_q;
  assign byte_sent_o = sent_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd)); // R2

  AST_CTRL_TOP_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_ctrl) |=> (bus_rdata[7:6] == 2'b11)); // R3

  AST_INIT_STATUS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_ctrl && !bus_wdata[CT_INIT]) |=> (sts_q == STAT_INIT)); // R4

  AST_BUSY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_ctrl && bus_wdata[CT_INIT] && bus_wdata[CT_SEL] && bus_wdata[CT_STB])
      |=> !sts_q[ST_BUSY_N]); // R5

  AST_PULSE_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
    byte_sent_o |-> $past(bus_wr && sel_ctrl)); // R5

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_stat && !bus_wr) |=> !irq_o); // R7

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_data && !sel_stat && !sel_ctrl) |=> (bus_rdata == UNMAPPED_RD)); // R2

  AST_DATA_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_data) |=> (!byte_sent_o && $stable(sts_q))); // R10

endmodule

// File: tb/lpt_regif_bench.sv
module lpt_regif_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, pdata_o, pdata_i;
  logic       irq_o, byte_sent_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  lpt_regif u_lpt_regif (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .pdata_o     (pdata_o),
    .byte_sent_o (byte_sent_o),
    .pdata_i     (pdata_i)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk("R1", "irq after reset", {7'd0, irq_o}, 8'h00);
    chk("R1", "pulse after reset", {7'd0, byte_sent_o}, 8'h00);
    chk("R1", "pdata_o after reset", pdata_o, 8'hFF);
    rd(3'd1, v); chk("R1", "status reset", v, 8'hF9);
    rd(3'd2, v); chk("R1", "control reset", v, 8'hCC);
    rd(3'd0, v); chk("R1", "data reset", v, 8'hFF);
  endtask

  task automatic t_map();
    logic [7:0] v;
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), v); chk("R2", "unmapped read", v, 8'hFF);
    end
    wr(3'd2, 8'h0C);
    rd(3'd2, v); chk("R3", "control top bits forced", v, 8'hCC);
    @(negedge clk);
    chk("R2", "rdata held", bus_rdata, 8'hCC);
  endtask

  task automatic t_send();
    logic [7:0] v;
    do_reset();
    wr(3'd0, 8'h5A);
    chk("R10", "pdata_o after data write", pdata_o, 8'h5A);
    chk("R10", "no pulse on data write", {7'd0, byte_sent_o}, 8'h00);
    wr(3'd2, 8'hCD);
    chk("R5", "pulse after strobe", {7'd0, byte_sent_o}, 8'h01);
    chk("R5", "pdata_o during pulse", pdata_o, 8'h5A);
    @(negedge clk);
    chk("R5", "pulse one cycle", {7'd0, byte_sent_o}, 8'h00);
    rd(3'd1, v); chk("R5", "busy cleared", v, 8'h79);
    rd(3'd1, v); chk("R8", "strobe high holds status", v, 8'h79);
    wr(3'd2, 8'hCC);
    chk("R6", "no irq with enable off", {7'd0, irq_o}, 8'h00);
    rd(3'd1, v); chk("R8", "first handshake read", v, 8'h79);
    rd(3'd1, v); chk("R8", "ack cleared", v, 8'h39);
    rd(3'd1, v); chk("R8", "ack and busy set", v, 8'hF9);
    rd(3'd1, v); chk("R8", "busy high holds status", v, 8'hF9);
    wr(3'd2, 8'hCD); wr(3'd2, 8'hCD);
    chk("R5", "no pulse without strobe edge", {7'd0, byte_sent_o}, 8'h00);
    rd(3'd1, v); chk("R5", "busy still cleared", v, 8'h79);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    do_reset();
    wr(3'd2, 8'hDC);
    chk("R6", "stored enable was off", {7'd0, irq_o}, 8'h00);
    wr(3'd2, 8'hDC);
    chk("R6", "irq raised", {7'd0, irq_o}, 8'h01);
    wr(3'd0, 8'h11);
    chk("R10", "irq kept over data write", {7'd0, irq_o}, 8'h01);
    rd(3'd1, v);
    chk("R7", "irq cleared by status read", {7'd0, irq_o}, 8'h00);
    wr(3'd2, 8'hDD);
    chk("R6", "strobe high gives no irq", {7'd0, irq_o}, 8'h00);
    wr(3'd2, 8'hD4);
    chk("R6", "select low gives no irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] v;
    do_reset();
    wr(3'd2, 8'hCD);
    rd(3'd1, v); chk("R5", "busy low before init", v, 8'h79);
    wr(3'd2, 8'hC8);
    rd(3'd1, v); chk("R4", "init status", v, 8'hD8);
    rd(3'd2, v); chk("R3", "control readback", v, 8'hC8);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    do_reset();
    wr(3'd0, 8'hA5);
    pdata_i = 8'h33;
    wr(3'd2, 8'hEC);
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R9", "input latch read", v, 8'h33);
    pdata_i = 8'h6E;
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R9", "input latch follows", v, 8'h6E);
    wr(3'd2, 8'hCC);
    pdata_i = 8'h00;
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R9", "output latch read", v, 8'hA5);
    wr(3'd2, 8'hEC);
    @(negedge clk);
    wr(3'd2, 8'hCC);
    wr(3'd2, 8'hEC);
    rd(3'd0, v); chk("R9", "input latch resampled", v, 8'h00);
  endtask

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; pdata_i = 8'h00;
    rst = 1'b1;
    t_reset();
    t_map();
    t_send();
    t_irq();
    t_init();
    t_dir();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule